// File: doc/BRIEF.md
# Wrapping DMA Address Generator

This block produces the address of each word that one side of a DMA channel touches. A load strobe captures a base pointer and a window selection. Each advance strobe then moves the address forward by one 32-bit word (4 bytes). When the selected window has been fully walked, the next advance brings the address back to the base, so the same region is walked again.

The window is picked with a 3-bit code that is looked up in one of two tables. The memory-side table offers large windows, from 32 to 2048 words. The peripheral-side table offers small windows, from 1 to 64 words. On either side, code 0 means a linear walk with no window. A one-word window keeps the address pinned at the base, which is how a single fixed peripheral register is addressed for every word. Data movement and bus signalling belong to other blocks.

Top module: `wrap_addr_gen`

## Requirements
- R1: After reset the address output is 0 and the generator is in linear mode with its word counter at zero.
- R2: A load strobe makes the address equal to the base input one cycle later, and restarts the in-window word count at zero, even part-way through a window.
- R3: When load and advance are both high in one cycle, the load wins: the address becomes the base and the advance is dropped.
- R4: With code 0 on either side, each advance adds 4 to the address with no return to the base; the sum wraps modulo 2^ADDR_W.
- R5: With table select 0 (memory side), code c in 1..7 gives a window of 2^(c+4) words, so 32, 64, 128, 256, 512, 1024 or 2048.
- R6: With table select 1 (peripheral side), code c in 1..7 gives a window of 2^(c-1) words, so 1, 2, 4, 8, 16, 32 or 64.
- R7: Within a window of W words, advances 1 to W-1 each add 4. Advance W puts the address back to the base on that same strobe, and the pattern repeats.
- R8: With a one-word window (peripheral side, code 1) the address stays at the base for every advance.
- R9: In a cycle with neither load nor advance, the address does not change.
- R10: Base, code and table select are sampled only on a load. Changing them between loads has no effect on the address sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_i | input | ADDR_W | Base pointer captured on load |
| wrap_code_i | input | 3 | Window code, 0 means no wrap |
| side_i | input | 1 | Table select: 0 memory side, 1 peripheral side |
| load_i | input | 1 | Start strobe: capture base and window |
| adv_i | input | 1 | Word-advance strobe |
| addr_o | output | ADDR_W | Current word address |

## Verification
The assertions assume that the base pointer is word aligned and that the window seen by the core comes from the decoder, which always yields zero or a power of two. The stimulus therefore uses only base values that are multiples of 4. It reaches the window tables only through the code and table-select ports, so the power-of-two assumption always holds. It also changes those inputs between loads, to show that the generator holds its captured settings until the next load.

// File: rtl/wag_pkg.sv
package wag_pkg;
    localparam int CODE_W = 3;
    localparam int NUM_CODES = 1 << CODE_W;

    typedef enum logic {
        SIDE_MEM = 1'b0,
        SIDE_PER = 1'b1
    } side_e;
endpackage

// File: rtl/wag_window_dec.sv
module wag_window_dec
    import wag_pkg::*;
#(
    parameter int MEM_LOG2 = 5,
    parameter int PER_LOG2 = 0,
    parameter int WIN_W    = 12
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              side_i,
    output logic [WIN_W-1:0]  win_o
);
    logic [WIN_W-1:0] mem_tbl [NUM_CODES];
    logic [WIN_W-1:0] per_tbl [NUM_CODES];

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_tbl
        if (g == 0) begin : g_lin
            assign mem_tbl[g] = '0;
            assign per_tbl[g] = '0;
        end else begin : g_win
            assign mem_tbl[g] = WIN_W'(1) << (MEM_LOG2 + g - 1);
            assign per_tbl[g] = WIN_W'(1) << (PER_LOG2 + g - 1);
        end
    end

    always_comb begin
        if (side_e'(side_i) == SIDE_PER) win_o = per_tbl[code_i];
        else                             win_o = mem_tbl[code_i];
    end

    // R5 R6: every window is zero or a single power of two
    always_comb begin
        assert_win_pow2_R5: assert ($onehot0(win_o));
    end
    // R4: code 0 selects the linear mode
    always_comb begin
        assert_code0_linear_R4: assert (code_i != '0 || win_o == '0);
    end
endmodule

// File: rtl/wag_addr_core.sv
module wag_addr_core #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int WIN_W      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [WIN_W-1:0]  win_i,
    input  logic              load_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] base;
        logic [WIN_W-1:0]  win;
        logic [WIN_W-1:0]  cnt;
    } st_t;

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    st_t st_q, st_d;
    logic last_word;
    logic linear;

    assign linear    = (st_q.win == '0);
    assign last_word = !linear && (st_q.cnt == st_q.win - WIN_W'(1));

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.addr = base_i;
            st_d.base = base_i;
            st_d.win  = win_i;
            st_d.cnt  = '0;
        end else if (adv_i) begin
            if (last_word) begin
                st_d.addr = st_q.base;
                st_d.cnt  = '0;
            end else begin
                st_d.addr = st_q.addr + STEP;
                if (!linear) st_d.cnt = st_q.cnt + WIN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q.addr;

    assert_load_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> addr_o == $past(base_i));
    assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && adv_i) |=> st_q.cnt == '0);
    assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && linear) |=> addr_o == $past(addr_o) + STEP);
    assert_cnt_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !linear |-> st_q.cnt < st_q.win);
    assert_wrap_to_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && last_word) |=> addr_o == st_q.base);
    assert_one_word_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.win == WIN_W'(1) && !load_i) |=> $stable(addr_o));
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> $stable(addr_o));
endmodule

// File: rtl/wrap_addr_gen.sv
module wrap_addr_gen
    import wag_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int MEM_LOG2   = 5,
    parameter int PER_LOG2   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [2:0]        wrap_code_i,
    input  logic              side_i,
    input  logic              load_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int MAX_LOG2 = (MEM_LOG2 > PER_LOG2) ? MEM_LOG2 : PER_LOG2;
    localparam int WIN_W    = MAX_LOG2 + NUM_CODES - 1;

    logic [WIN_W-1:0] win;

    wag_window_dec #(
        .MEM_LOG2 (MEM_LOG2),
        .PER_LOG2 (PER_LOG2),
        .WIN_W    (WIN_W)
    ) u_dec (
        .code_i (wrap_code_i),
        .side_i (side_i),
        .win_o  (win)
    );

    wag_addr_core #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES),
        .WIN_W      (WIN_W)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .base_i (base_i),
        .win_i  (win),
        .load_i (load_i),
        .adv_i  (adv_i),
        .addr_o (addr_o)
    );
endmodule

// File: tb/sim_wrap_addr_gen.sv
module sim_wrap_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_i = '0;
    logic [2:0]  wrap_code_i = '0;
    logic        side_i = 1'b0;
    logic        load_i = 1'b0;
    logic        adv_i = 1'b0;
    logic [31:0] addr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    longint m_addr = 0, m_base = 0, m_win = 0, m_cnt = 0;

    always #2 clk = ~clk;

    wrap_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .base_i(base_i), .wrap_code_i(wrap_code_i),
        .side_i(side_i), .load_i(load_i), .adv_i(adv_i), .addr_o(addr_o)
    );

    function automatic longint win_of(input int code, input bit side);
        if (code == 0) return 0;
        if (side) return longint'(1) << (code - 1);   // R6
        return longint'(1) << (code + 4);             // R5
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (longint'(addr_o) != m_addr) begin
            fails++;
            $display("FAIL %s: addr actual %h expected %h", tag, addr_o, m_addr[31:0]);
        end
    endtask

    task automatic step(input bit ld, input bit ad, input string tag);
        @(negedge clk);
        load_i = ld;
        adv_i  = ad;
        @(posedge clk);
        if (ld) begin
            m_addr = longint'(base_i);
            m_base = longint'(base_i);
            m_win  = win_of(int'(wrap_code_i), side_i);
            m_cnt  = 0;
        end else if (ad) begin
            if (m_win != 0 && m_cnt == m_win - 1) begin
                m_addr = m_base;
                m_cnt  = 0;
            end else begin
                m_addr = (m_addr + 4) & 64'hFFFF_FFFF;
                if (m_win != 0) m_cnt++;
            end
        end
        @(negedge clk);
        compare(tag);
        load_i = 1'b0;
        adv_i  = 1'b0;
    endtask

    task automatic start(input logic [31:0] b, input int code, input bit side, input string tag);
        @(negedge clk);
        base_i = b;
        wrap_code_i = 3'(code);
        side_i = side;
        step(1'b1, 1'b0, tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        step(1'b0, 1'b0, "R1 after reset");

        // memory side, 32-word window
        start(32'h0000_1000, 1, 1'b0, "R2 load");
        run(70, "R5 R7 mem code1");
        // every memory code
        for (int c = 2; c <= 7; c++) begin
            start(32'h0010_0000, c, 1'b0, "R2 load");
            run(int'(win_of(c, 1'b0)) + 3, "R5 R7 mem window");
        end
        // peripheral side
        start(32'h7000_0040, 1, 1'b1, "R2 load");
        run(6, "R8 one word fixed");
        for (int c = 2; c <= 7; c++) begin
            start(32'h7000_0100, c, 1'b1, "R2 load");
            run(2 * int'(win_of(c, 1'b1)) + 1, "R6 R7 per window");
        end
        // linear with address-width wrap, both tables
        start(32'hFFFF_FFF0, 0, 1'b0, "R2 load");
        run(8, "R4 linear mem");
        start(32'h0000_0200, 0, 1'b1, "R2 load");
        run(5, "R4 linear per");
        // idle holds
        step(1'b0, 1'b0, "R9 idle");
        step(1'b0, 1'b0, "R9 idle");
        // load beats advance
        start(32'h0000_3000, 4, 1'b1, "R2 load");
        run(3, "R6 per code4");
        @(negedge clk);
        base_i = 32'h0000_5000;
        step(1'b1, 1'b1, "R3 load beats advance");
        run(2, "R3 after load");
        // inputs change without load
        @(negedge clk);
        base_i = 32'hDEAD_0000;
        wrap_code_i = 3'd1;
        side_i = 1'b1;
        run(10, "R10 inputs ignored");
        // reload mid-window
        start(32'h0000_8000, 2, 1'b1, "R2 reload");
        run(1, "R2 mid");
        start(32'h0000_8000, 2, 1'b1, "R2 reload mid window");
        run(3, "R2 counter restarted");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule